// File: doc/BRIEF.md
# Processor Trap Detection Unit

This unit sits beside a processor core and raises the error traps that software cannot mask. Every cycle it looks at the data access on the core bus (its address, its size and a valid strobe), at the instruction fetch address, at each write of the stack pointer, and at each divide start with its divisor. When one of these is illegal, it sets a sticky flag for that cause:

- **Address error:** an odd word access, an access outside implemented data memory, or a fetch from unimplemented program space or from the vector table.
- **Stack error:** the stack pointer goes above a limit register that software writes, or below a fixed floor at byte address 0x0200.
- **Arithmetic error:** a divide starts with a divisor of zero.

A single request line goes high whenever any flag is set. The request has no enable or priority input, so no interrupt priority setting can hold it back.

Software clears each flag with a write-one-to-clear pulse. A small two-state machine, REQ_IDLE and REQ_RAISED, tracks whether any cause is pending and drives the request. Vectoring, priority arbitration and the stack operations themselves belong to other blocks.

Top module: `trap_detect_unit`

## Requirements
- R1: While reset is low, and in the cycle after it is released, all flags and `trap_req` are 0. The stack limit register resets to 0x27FE.
- R2: A valid word access (`d_word`=1) to an odd byte address sets flag bit 0 (address error). A byte access (`d_word`=0) to an odd address sets nothing.
- R3: A valid data access of either size to an address above `DATA_TOP` (default 0x27FF) sets flag bit 0. An access to 0x27FF itself does not.
- R4: The fetch input carries PC bits 22:1, and PC bit 0 is zero. A valid fetch whose PC is above `PROG_TOP` (default 0x017FFE) sets flag bit 0. So does a fetch whose PC lies in the vector table span [0x000004, 0x000080). PCs 0x000000 to 0x000002 and 0x000080 up to `PROG_TOP` set nothing.
- R5: A stack pointer write with a value above the stack limit register sets flag bit 1 (stack error). A value equal to the limit does not.
- R6: A stack pointer write with a value below 0x0200 sets flag bit 1. A value of 0x0200 does not.
- R7: The stack checks run only in cycles with `sp_we`=1. A write to the limit register takes effect from the next cycle, so a stack check in the same cycle still uses the old limit.
- R8: A divide start with a divisor of zero sets flag bit 2 (arithmetic error). A nonzero divisor, or a zero divisor without a start, sets nothing.
- R9: Each flag stays set until a 1 arrives on the matching `flag_clr` bit (bit 0 address, bit 1 stack, bit 2 arithmetic). A clear bit has no effect on the other flags. A new event in the same cycle as its clear leaves the flag set.
- R10: Flags update on the clock edge that samples the event. When several causes occur in one cycle, every matching flag is set. `trap_req` is 1 exactly when at least one flag is 1, in the same cycle as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_valid | input | 1 | Data access valid this cycle |
| d_word | input | 1 | 1 = word access, 0 = byte access |
| d_addr | input | 16 | Data byte address |
| f_valid | input | 1 | Instruction fetch valid this cycle |
| f_addr | input | 22 | Fetch PC bits 22:1 |
| sp_we | input | 1 | Stack pointer written this cycle |
| sp_val | input | 16 | New stack pointer value |
| lim_we | input | 1 | Write strobe for the stack limit register |
| lim_wdata | input | 16 | New stack limit value |
| div_start | input | 1 | Divide begins this cycle |
| div_den | input | 16 | Divisor of the divide |
| flag_clr | input | 3 | Write-one-to-clear for each flag |
| trap_flags | output | 3 | Sticky flags: bit 0 address, bit 1 stack, bit 2 arithmetic |
| trap_req | output | 1 | Combined trap request |

## Verification
A wrong flag bit shows up at `trap_flags` one clock edge after the access that should have set it, or should have left it alone. Because the flags are sticky, the error then stays visible until the next clear.

A wrong REQ_IDLE/REQ_RAISED state shows up at once: `trap_req` disagrees with the OR of the flags in the same cycle.

A stale or wrongly loaded stack limit register cannot be seen directly. It shows up only on the next stack pointer write whose value lies between the expected limit and the one actually held. For this reason the bench writes the limit and then probes the pointer on both sides of the new value.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int N_CAUSE     = 3;
    localparam int CAUSE_ADDR  = 0;
    localparam int CAUSE_STACK = 1;
    localparam int CAUSE_MATH  = 2;

    typedef logic [N_CAUSE-1:0] cause_vec_t;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

endpackage

// File: rtl/trap_addr_chk.sv
module trap_addr_chk #(
    parameter int unsigned DAW = 16,
    parameter int unsigned PAW = 23,
    parameter logic [DAW-1:0] DATA_TOP = 16'h27FF,
    parameter logic [PAW-1:0] PROG_TOP = 23'h017FFE,
    parameter logic [PAW-1:0] VEC_LO   = 23'h000004,
    parameter logic [PAW-1:0] VEC_HI   = 23'h000080
) (
    input  logic           d_valid,
    input  logic           d_word,
    input  logic [DAW-1:0] d_addr,
    input  logic           f_valid,
    input  logic [PAW-2:0] f_addr,
    output logic           addr_err
);

    logic [PAW-1:0] pc_full;
    logic           data_misalign;
    logic           data_unimpl;
    logic           fetch_unimpl;
    logic           fetch_vector;

    always_comb begin
        pc_full       = {f_addr, 1'b0};
        data_misalign = d_valid && d_word && d_addr[0];
        data_unimpl   = d_valid && (d_addr > DATA_TOP);
        fetch_unimpl  = f_valid && (pc_full > PROG_TOP);
        fetch_vector  = f_valid && (pc_full >= VEC_LO) && (pc_full < VEC_HI);
        addr_err      = data_misalign || data_unimpl || fetch_unimpl || fetch_vector;
    end

endmodule

// File: rtl/trap_stack_chk.sv
module trap_stack_chk #(
    parameter int unsigned DAW = 16,
    parameter logic [DAW-1:0] STK_FLOOR   = 16'h0200,
    parameter logic [DAW-1:0] LIMIT_RESET = 16'h27FE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sp_we,
    input  logic [DAW-1:0] sp_val,
    input  logic           lim_we,
    input  logic [DAW-1:0] lim_wdata,
    output logic [DAW-1:0] limit_q,
    output logic           stack_err
);

    logic above_limit;
    logic below_floor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RESET;
        end else if (lim_we) begin
            limit_q <= lim_wdata;
        end
    end

    always_comb begin
        above_limit = sp_val > limit_q;
        below_floor = sp_val < STK_FLOOR;
        stack_err   = sp_we && (above_limit || below_floor);
    end

endmodule

// File: rtl/trap_div_chk.sv
module trap_div_chk #(
    parameter int unsigned DVW = 16
) (
    input  logic           div_start,
    input  logic [DVW-1:0] div_den,
    output logic           math_err
);

    always_comb begin
        math_err = div_start && (div_den == '0);
    end

endmodule

// File: rtl/trap_flag_fsm.sv
module trap_flag_fsm
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_vec_t set_vec,
    input  cause_vec_t clr_vec,
    output cause_vec_t flags,
    output logic       req
);

    cause_vec_t flags_d;
    req_state_e state_q;
    req_state_e state_d;

    genvar gi;
    generate
        for (gi = 0; gi < N_CAUSE; gi++) begin : g_flag
            always_comb begin
                flags_d[gi] = set_vec[gi] || (flags[gi] && !clr_vec[gi]);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[gi] <= 1'b0;
                end else begin
                    flags[gi] <= flags_d[gi];
                end
            end
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (|flags_d) begin
                    state_d = REQ_RAISED;
                end
            end
            REQ_RAISED: begin
                if (!(|flags_d)) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE:   req = 1'b0;
            REQ_RAISED: req = 1'b1;
            default:    req = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_detect_unit.sv
module trap_detect_unit
    import trap_pkg::*;
#(
    parameter int unsigned DAW = 16,
    parameter int unsigned PAW = 23,
    parameter int unsigned DVW = 16,
    parameter logic [DAW-1:0] DATA_TOP    = 16'h27FF,
    parameter logic [PAW-1:0] PROG_TOP    = 23'h017FFE,
    parameter logic [PAW-1:0] VEC_LO      = 23'h000004,
    parameter logic [PAW-1:0] VEC_HI      = 23'h000080,
    parameter logic [DAW-1:0] STK_FLOOR   = 16'h0200,
    parameter logic [DAW-1:0] LIMIT_RESET = 16'h27FE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           d_valid,
    input  logic           d_word,
    input  logic [DAW-1:0] d_addr,
    input  logic           f_valid,
    input  logic [PAW-2:0] f_addr,
    input  logic           sp_we,
    input  logic [DAW-1:0] sp_val,
    input  logic           lim_we,
    input  logic [DAW-1:0] lim_wdata,
    input  logic           div_start,
    input  logic [DVW-1:0] div_den,
    input  logic [2:0]     flag_clr,
    output logic [2:0]     trap_flags,
    output logic           trap_req
);

    logic           addr_err;
    logic           stack_err;
    logic           math_err;
    logic [DAW-1:0] stk_limit;
    cause_vec_t     set_vec;

    trap_addr_chk #(
        .DAW(DAW), .PAW(PAW), .DATA_TOP(DATA_TOP),
        .PROG_TOP(PROG_TOP), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
    ) u_addr (
        .d_valid(d_valid), .d_word(d_word), .d_addr(d_addr),
        .f_valid(f_valid), .f_addr(f_addr), .addr_err(addr_err)
    );

    trap_stack_chk #(
        .DAW(DAW), .STK_FLOOR(STK_FLOOR), .LIMIT_RESET(LIMIT_RESET)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .sp_val(sp_val),
        .lim_we(lim_we), .lim_wdata(lim_wdata),
        .limit_q(stk_limit), .stack_err(stack_err)
    );

    trap_div_chk #(.DVW(DVW)) u_div (
        .div_start(div_start), .div_den(div_den), .math_err(math_err)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[CAUSE_ADDR]  = addr_err;
        set_vec[CAUSE_STACK] = stack_err;
        set_vec[CAUSE_MATH]  = math_err;
    end

    trap_flag_fsm u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(flag_clr),
        .flags(trap_flags), .req(trap_req)
    );

endmodule

// File: rtl/trap_detect_chk.sv
module trap_detect_chk #(
    parameter int unsigned DAW = 16,
    parameter int unsigned PAW = 23,
    parameter int unsigned DVW = 16,
    parameter logic [DAW-1:0] DATA_TOP  = 16'h27FF,
    parameter logic [PAW-1:0] PROG_TOP  = 23'h017FFE,
    parameter logic [PAW-1:0] VEC_LO    = 23'h000004,
    parameter logic [PAW-1:0] VEC_HI    = 23'h000080,
    parameter logic [DAW-1:0] STK_FLOOR = 16'h0200
) (
    input logic           clk,
    input logic           rst_n,
    input logic           d_valid,
    input logic           d_word,
    input logic [DAW-1:0] d_addr,
    input logic           f_valid,
    input logic [PAW-2:0] f_addr,
    input logic           sp_we,
    input logic [DAW-1:0] sp_val,
    input logic           div_start,
    input logic [DVW-1:0] div_den,
    input logic [2:0]     flag_clr,
    input logic [2:0]     trap_flags,
    input logic           trap_req,
    input logic [DAW-1:0] stk_limit
);

    // R1: flags are clear in the cycle after a reset edge
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (trap_flags == 3'b000));

    a_r2_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_word && d_addr[0]) |=> trap_flags[0]);

    a_r3_unimpl_data: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && (d_addr > DATA_TOP)) |=> trap_flags[0]);

    a_r4_bad_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (f_valid && (({f_addr, 1'b0} > PROG_TOP) ||
                     (({f_addr, 1'b0} >= VEC_LO) && ({f_addr, 1'b0} < VEC_HI))))
        |=> trap_flags[0]);

    a_r5_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && (sp_val > stk_limit)) |=> trap_flags[1]);

    a_r6_below_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && (sp_val < STK_FLOOR)) |=> trap_flags[1]);

    a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (div_start && (div_den == '0)) |=> trap_flags[2]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(trap_flags) & ~$past(flag_clr)) & ~trap_flags) == 3'b000));

    a_r10_req_any: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == (|trap_flags));

endmodule

bind trap_detect_unit trap_detect_chk #(
    .DAW(DAW), .PAW(PAW), .DVW(DVW), .DATA_TOP(DATA_TOP),
    .PROG_TOP(PROG_TOP), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI),
    .STK_FLOOR(STK_FLOOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_word(d_word),
    .d_addr(d_addr), .f_valid(f_valid), .f_addr(f_addr), .sp_we(sp_we),
    .sp_val(sp_val), .div_start(div_start), .div_den(div_den),
    .flag_clr(flag_clr), .trap_flags(trap_flags), .trap_req(trap_req),
    .stk_limit(stk_limit)
);

// File: tb/trap_detect_unit_tb.sv
`timescale 1ns/1ps
module trap_detect_unit_tb;

    localparam logic [15:0] DATA_TOP = 16'h27FF;
    localparam logic [22:0] PROG_TOP = 23'h017FFE;
    localparam logic [15:0] FLOOR    = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_valid = 0, d_word = 0, f_valid = 0, sp_we = 0, lim_we = 0, div_start = 0;
    logic [15:0] d_addr = 0, sp_val = 0, lim_wdata = 0, div_den = 0;
    logic [21:0] f_addr = 0;
    logic [2:0]  flag_clr = 0;
    logic [2:0]  trap_flags;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [2:0]  m_flags = 0;
    logic [15:0] m_limit = 16'h27FE;

    always #4 clk = ~clk;

    trap_detect_unit u_dut (
        .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_word(d_word),
        .d_addr(d_addr), .f_valid(f_valid), .f_addr(f_addr), .sp_we(sp_we),
        .sp_val(sp_val), .lim_we(lim_we), .lim_wdata(lim_wdata),
        .div_start(div_start), .div_den(div_den), .flag_clr(flag_clr),
        .trap_flags(trap_flags), .trap_req(trap_req)
    );

    function automatic logic [2:0] causes();
        logic [22:0] pc;
        logic [2:0]  c;
        pc = {f_addr, 1'b0};
        c = 3'b000;
        if (d_valid && ((d_word && d_addr[0]) || d_addr > DATA_TOP)) c[0] = 1'b1;
        if (f_valid && (pc > PROG_TOP || (pc >= 23'h4 && pc < 23'h80))) c[0] = 1'b1;
        if (sp_we && (sp_val > m_limit || sp_val < FLOOR)) c[1] = 1'b1;
        if (div_start && div_den == 16'h0) c[2] = 1'b1;
        return c;
    endfunction

    task automatic idle();
        d_valid = 0; d_word = 0; f_valid = 0; sp_we = 0;
        lim_we = 0; div_start = 0; flag_clr = 0;
    endtask

    // inputs are set just after a falling edge; outputs checked at the next one
    task automatic tick(input string tag);
        m_flags = causes() | (m_flags & ~flag_clr);
        if (lim_we) m_limit = lim_wdata;
        @(negedge clk);
        checks++;
        if (trap_flags !== m_flags || trap_req !== (|m_flags)) begin
            errors++;
            $display("FAIL %s: flags=%b req=%b expected flags=%b req=%b",
                     tag, trap_flags, trap_req, m_flags, |m_flags);
        end
        idle();
    endtask

    task automatic clear_all();
        flag_clr = 3'b111;
        tick("R9 clear all");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (trap_flags !== 3'b000 || trap_req !== 1'b0) begin
            errors++;
            $display("FAIL R1: flags=%b req=%b expected flags=000 req=0", trap_flags, trap_req);
        end
        rst_n = 1'b1;
        tick("R1 after release");

        // R2 alignment
        d_valid = 1; d_word = 1; d_addr = 16'h1001; tick("R2 odd word");
        clear_all();
        d_valid = 1; d_word = 0; d_addr = 16'h1001; tick("R2 odd byte");
        d_valid = 1; d_word = 1; d_addr = 16'h1000; tick("R2 even word");
        // R3 unimplemented data
        d_valid = 1; d_addr = 16'h27FF; tick("R3 top byte");
        d_valid = 1; d_addr = 16'h2800; tick("R3 above top");
        clear_all();
        // R4 fetch
        f_valid = 1; f_addr = 22'(23'h017FFE >> 1); tick("R4 last pc");
        f_valid = 1; f_addr = 22'(23'h018000 >> 1); tick("R4 above top");
        clear_all();
        f_valid = 1; f_addr = 22'(23'h000002 >> 1); tick("R4 reset slot");
        f_valid = 1; f_addr = 22'(23'h000040 >> 1); tick("R4 vector table");
        clear_all();
        f_valid = 1; f_addr = 22'(23'h000080 >> 1); tick("R4 after vectors");
        // R5, R6 stack
        sp_we = 1; sp_val = 16'h27FE; tick("R5 equal limit");
        sp_we = 1; sp_val = 16'h2800; tick("R5 above limit");
        clear_all();
        sp_we = 1; sp_val = 16'h0200; tick("R6 at floor");
        sp_we = 1; sp_val = 16'h01FE; tick("R6 below floor");
        clear_all();
        // R7 stack checked only on writes; limit takes effect next cycle
        sp_val = 16'h0000; tick("R7 no write");
        lim_we = 1; lim_wdata = 16'h1000; sp_we = 1; sp_val = 16'h2000; tick("R7 old limit");
        sp_we = 1; sp_val = 16'h1000; tick("R7 new limit equal");
        sp_we = 1; sp_val = 16'h1002; tick("R7 new limit above");
        clear_all();
        // R8 divide
        div_start = 1; div_den = 16'h0001; tick("R8 nonzero");
        div_den = 16'h0000; tick("R8 zero no start");
        div_start = 1; div_den = 16'h0000; tick("R8 zero divisor");
        // R9 sticky and per-bit clear
        tick("R9 holds");
        flag_clr = 3'b011; tick("R9 other bits");
        flag_clr = 3'b100; div_start = 1; div_den = 0; tick("R9 set beats clear");
        flag_clr = 3'b100; tick("R9 cleared");
        // R10 several causes at once
        d_valid = 1; d_word = 1; d_addr = 16'h0003; sp_we = 1; sp_val = 16'h0000;
        div_start = 1; div_den = 0; tick("R10 all causes");
        flag_clr = 3'b010; tick("R10 partial clear");
        clear_all();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            d_valid   = $urandom_range(0, 1);
            d_word    = $urandom_range(0, 1);
            d_addr    = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 16'h2900));
            f_valid   = $urandom_range(0, 1);
            f_addr    = ($urandom_range(0, 3) == 0) ? 22'($urandom_range(0, 80)) : 22'($urandom_range(0, 23'h00D000));
            sp_we     = $urandom_range(0, 2) == 0;
            sp_val    = 16'($urandom_range(16'h01F0, 16'h2A00));
            lim_we    = $urandom_range(0, 15) == 0;
            lim_wdata = 16'($urandom_range(16'h0400, 16'h2900));
            div_start = $urandom_range(0, 2) == 0;
            div_den   = ($urandom_range(0, 2) == 0) ? 16'h0 : 16'($urandom);
            flag_clr  = 3'($urandom);
            tick("R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule